// File: doc/BRIEF.md
# DDR2 power-up initialization sequencer

This block sits on the controller side of a DDR2 memory channel. It owns the command bus from reset until the memory is ready. The bus it drives is clock enable, chip select, row strobe, column strobe, write enable, bank address and address. It holds clock enable low through the long power-on wait, then raises it and waits again. After that it issues, in a fixed order, the precharge-all commands, the writes to the three extended mode registers and to the main mode register, a run of auto-refreshes, and the output-driver calibration enter/leave pair. When the last of these has settled, it raises a done flag and hands the bus over.

Every wait is a clock-cycle count parameter. By default each is derived from the clock period in picoseconds, and a simulation can override any of them with short values. The mode-register contents come from configuration inputs. The sequencer forces only the bits the procedure itself dictates: DLL enable, DLL reset and calibration control. Every cycle that carries no command drives NOP with chip select low. The calibration enter write is held back until a fixed number of cycles has elapsed since the DLL-reset write. An optional output register stage delays the whole bus by one cycle.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: During reset, and for PWRUP_CYC cycles after reset is released, cke is 0 and the bus carries NOP. NOP means cs_n=0, ras_n=1, cas_n=1 and we_n=1, with ba=0 and addr=0. During this time init_done is 0.
- R2: cke rises in cycle PWRUP_CYC after reset release and never falls again. Exactly CKE_CYC cycles later a precharge-all is driven: cs_n=0, ras_n=0, cas_n=1 and we_n=0, with addr bit 10 set, every other addr bit 0, and ba=0.
- R3: After the first precharge-all, four mode-register writes follow, each encoded as cs_n, ras_n, cas_n and we_n all 0. First comes ba=2 with addr=emr2_cfg. Next comes ba=3 with addr=emr3_cfg. Then ba=1 with addr=emr1_cfg, except that bit 0 is forced to 0 and bits 9..7 are forced to 000. Last comes ba=0 with addr=mr_cfg, except that bit 8 is forced to 1 (the DLL reset).
- R4: The next command follows exactly TRP_CYC cycles after a precharge-all, TMRD_CYC cycles after a mode-register write and TRFC_CYC cycles after a refresh. Every cycle in between carries NOP with cke=1.
- R5: After the DLL-reset write comes a second precharge-all, then NUM_REF auto-refreshes. A refresh is encoded as cs_n=0, ras_n=0, cas_n=0 and we_n=1, with ba=0 and addr=0. After the refreshes comes a mode-register write with ba=0 and addr=mr_cfg, except that bit 8 is forced to 0.
- R6: The calibration enter write follows the normal-operation mode write. It is a mode-register write with ba=1 and addr=emr1_cfg, with bit 0 forced to 0 and bits 9..7 forced to 111. It is issued TMRD_CYC cycles after that mode write, or DLL_CYC cycles after the DLL-reset write, whichever is later. NOPs fill any extra wait. TMRD_CYC cycles after the enter write comes the calibration leave write: the same, but with bits 9..7 set to 000.
- R7: init_done rises exactly TMRD_CYC cycles after the calibration leave write. It then stays 1, and from that cycle on the bus carries NOP with cke=1.
- R8: With REG_OUT=1, every output shows in cycle n+1 the value it would show in cycle n with REG_OUT=0. The reset values are the same in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| mr_cfg | input | ADDR_W | Main mode-register value; bit 8 is overridden |
| emr1_cfg | input | ADDR_W | Extended register 1 value; bits 0 and 9..7 are overridden |
| emr2_cfg | input | ADDR_W | Extended register 2 value |
| emr3_cfg | input | ADDR_W | Extended register 3 value |
| mem_cke | output | 1 | Clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address |
| init_done | output | 1 | Sequence finished; bus handed over |

## Verification
Two instances run side by side under different timing sets and configuration words. The first has short refresh and mode-register gaps against a long DLL wait, so the calibration enter write must be held back by the DLL counter. The second has a short DLL wait, so the normal spacing alone sets its timing. Its configuration words leave bit 8 of the mode value clear and the calibration bits of extended register 1 clear. The first instance's words have those bits set. Between them the two instances show both directions of every forced bit. The second instance also uses the registered output stage, which separates a one-cycle skew from an ordering error. A behavioural model expands each parameter set into the full expected bus trace, which is compared against the outputs on every cycle, so a gap that is one cycle off, a wrong bank select or a missing refresh shows up in the cycle where it occurs.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

   typedef enum logic [3:0] {
      ST_PWR       = 4'd0,
      ST_CKE       = 4'd1,
      ST_PREA1     = 4'd2,
      ST_EMR2      = 4'd3,
      ST_EMR3      = 4'd4,
      ST_EMR1_DLL  = 4'd5,
      ST_MR_DLLRST = 4'd6,
      ST_PREA2     = 4'd7,
      ST_REF       = 4'd8,
      ST_MR_RUN    = 4'd9,
      ST_OCD_DEF   = 4'd10,
      ST_OCD_EXIT  = 4'd11,
      ST_DONE      = 4'd12
   } init_step_t;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] ENC_NOP = 4'b0111;
   localparam logic [3:0] ENC_PRE = 4'b0010;
   localparam logic [3:0] ENC_REF = 4'b0001;
   localparam logic [3:0] ENC_MRS = 4'b0000;

   function automatic int max2(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr2_init_step_ctl.sv
module ddr2_init_step_ctl
   import ddr2_init_pkg::*;
#(
   parameter int PWRUP_CYC = 80000,
   parameter int CKE_CYC   = 160,
   parameter int TRP_CYC   = 5,
   parameter int TMRD_CYC  = 2,
   parameter int TRFC_CYC  = 79,
   parameter int NUM_REF   = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       dll_ok,
   output init_step_t step_o,
   output logic       fire_o
);

   localparam int MAX_LEN = max2(max2(PWRUP_CYC, CKE_CYC),
                                 max2(max2(TRP_CYC, TMRD_CYC), TRFC_CYC));
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam int REF_W   = $clog2(NUM_REF + 1);

   init_step_t       step;
   logic [CNT_W-1:0] cnt;
   logic [REF_W-1:0] ref_idx;
   logic             fire;
   logic             at_last;
   logic             moving;

   function automatic int step_len(init_step_t s);
      case (s)
         ST_PWR:             return PWRUP_CYC;
         ST_CKE:             return CKE_CYC;
         ST_PREA1, ST_PREA2: return TRP_CYC;
         ST_REF:             return TRFC_CYC;
         ST_DONE:            return 1;
         default:            return TMRD_CYC;
      endcase
   endfunction

   always_comb begin
      fire    = (cnt == '0) && (step != ST_DONE) &&
                ((step != ST_OCD_DEF) || dll_ok);
      moving  = (cnt != '0) || fire;
      at_last = moving && (int'(cnt) == step_len(step) - 1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         step    <= ST_PWR;
         cnt     <= '0;
         ref_idx <= '0;
      end else if (at_last) begin
         cnt <= '0;
         if ((step == ST_REF) && (ref_idx != REF_W'(NUM_REF - 1))) begin
            ref_idx <= ref_idx + 1'b1;
         end else begin
            step <= init_step_t'(int'(step) + 1);
         end
      end else if (moving) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign step_o = step;
   assign fire_o = fire;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      int'(cnt) < step_len(step)); // R4

   AST_REF_BOUND: assert property (@(posedge clk) disable iff (rst)
      int'(ref_idx) < NUM_REF); // R5

endmodule

// File: rtl/ddr2_init_dll_timer.sv
module ddr2_init_dll_timer #(
   parameter int DLL_CYC = 200
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic ok
);

   localparam int DW = $clog2(DLL_CYC + 1);

   logic [DW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= DW'(1);
      end else if ((cnt != '0) && (cnt != DW'(DLL_CYC))) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign ok = (cnt == DW'(DLL_CYC));

   AST_DLL_ONCE: assert property (@(posedge clk) disable iff (rst)
      start |-> (cnt == '0)); // R3

   AST_DLL_HOLD: assert property (@(posedge clk) disable iff (rst)
      ok |=> ok); // R6

endmodule

// File: rtl/ddr2_init_cmd_enc.sv
module ddr2_init_cmd_enc
   import ddr2_init_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int BA_W   = 3
) (
   input  init_step_t        step,
   input  logic              fire,
   input  logic [ADDR_W-1:0] mr_cfg,
   input  logic [ADDR_W-1:0] emr1_cfg,
   input  logic [ADDR_W-1:0] emr2_cfg,
   input  logic [ADDR_W-1:0] emr3_cfg,
   output logic              cke,
   output logic [3:0]        ctl,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              done
);

   localparam logic [ADDR_W-1:0] BIT_A0  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] BIT_A8  = ADDR_W'(1) << 8;
   localparam logic [ADDR_W-1:0] BIT_A10 = ADDR_W'(1) << 10;
   localparam logic [ADDR_W-1:0] OCD_MSK = ADDR_W'(7) << 7;

   logic [ADDR_W-1:0] emr1_base;
   logic [1:0]        bank_sel;

   assign emr1_base = emr1_cfg & ~(OCD_MSK | BIT_A0);

   always_comb begin
      cke      = 1'b1;
      ctl      = ENC_NOP;
      bank_sel = 2'd0;
      addr     = '0;
      done     = 1'b0;
      case (step)
         ST_PWR:  cke  = 1'b0;
         ST_DONE: done = 1'b1;
         default: if (fire) begin
            case (step)
               ST_PREA1, ST_PREA2: begin
                  ctl  = ENC_PRE;
                  addr = BIT_A10;
               end
               ST_REF: ctl = ENC_REF;
               ST_EMR2: begin
                  ctl      = ENC_MRS;
                  bank_sel = 2'd2;
                  addr     = emr2_cfg;
               end
               ST_EMR3: begin
                  ctl      = ENC_MRS;
                  bank_sel = 2'd3;
                  addr     = emr3_cfg;
               end
               ST_EMR1_DLL, ST_OCD_EXIT: begin
                  ctl      = ENC_MRS;
                  bank_sel = 2'd1;
                  addr     = emr1_base;
               end
               ST_OCD_DEF: begin
                  ctl      = ENC_MRS;
                  bank_sel = 2'd1;
                  addr     = emr1_base | OCD_MSK;
               end
               ST_MR_DLLRST: begin
                  ctl  = ENC_MRS;
                  addr = mr_cfg | BIT_A8;
               end
               ST_MR_RUN: begin
                  ctl  = ENC_MRS;
                  addr = mr_cfg & ~BIT_A8;
               end
               default: ctl = ENC_NOP;
            endcase
         end
      endcase
   end

   generate
      if (BA_W > 2) begin : g_ba_wide
         assign ba = {{(BA_W-2){1'b0}}, bank_sel};
      end else begin : g_ba_narrow
         assign ba = bank_sel;
      end
   endgenerate

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
   import ddr2_init_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int BA_W      = 3,
   parameter int CLK_PS    = 2500,
   parameter int PWRUP_CYC = (200_000_000 + CLK_PS - 1) / CLK_PS,
   parameter int CKE_CYC   = (400_000 + CLK_PS - 1) / CLK_PS,
   parameter int TRP_CYC   = (12_500 + CLK_PS - 1) / CLK_PS,
   parameter int TMRD_CYC  = 2,
   parameter int TRFC_CYC  = (197_500 + CLK_PS - 1) / CLK_PS,
   parameter int NUM_REF   = 2,
   parameter int DLL_CYC   = 200,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] mr_cfg,
   input  logic [ADDR_W-1:0] emr1_cfg,
   input  logic [ADDR_W-1:0] emr2_cfg,
   input  logic [ADDR_W-1:0] emr3_cfg,
   output logic              mem_cke,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [BA_W-1:0]   mem_ba,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              init_done
);

   generate
      if (ADDR_W < 11) begin : g_chk_addr
         $error("ADDR_W must cover address bit 10");
      end
      if (BA_W < 2) begin : g_chk_ba
         $error("BA_W must be at least 2");
      end
      if ((PWRUP_CYC < 1) || (CKE_CYC < 1) || (TRP_CYC < 1) ||
          (TMRD_CYC < 1) || (TRFC_CYC < 1) || (DLL_CYC < 1)) begin : g_chk_wait
         $error("every wait count must be at least one cycle");
      end
      if (NUM_REF < 2) begin : g_chk_ref
         $error("NUM_REF must be at least 2");
      end
   endgenerate

   init_step_t        step;
   logic              fire;
   logic              dll_ok;
   logic              dll_start;
   logic              e_cke;
   logic [3:0]        e_ctl;
   logic [BA_W-1:0]   e_ba;
   logic [ADDR_W-1:0] e_addr;
   logic              e_done;

   ddr2_init_step_ctl #(
      .PWRUP_CYC(PWRUP_CYC), .CKE_CYC(CKE_CYC), .TRP_CYC(TRP_CYC),
      .TMRD_CYC(TMRD_CYC), .TRFC_CYC(TRFC_CYC), .NUM_REF(NUM_REF)
   ) u_ctl (
      .clk(clk), .rst(rst), .dll_ok(dll_ok), .step_o(step), .fire_o(fire)
   );

   assign dll_start = fire && (step == ST_MR_DLLRST);

   ddr2_init_dll_timer #(.DLL_CYC(DLL_CYC)) u_dll (
      .clk(clk), .rst(rst), .start(dll_start), .ok(dll_ok)
   );

   ddr2_init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
      .step(step), .fire(fire),
      .mr_cfg(mr_cfg), .emr1_cfg(emr1_cfg), .emr2_cfg(emr2_cfg), .emr3_cfg(emr3_cfg),
      .cke(e_cke), .ctl(e_ctl), .ba(e_ba), .addr(e_addr), .done(e_done)
   );

   generate
      if (REG_OUT) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               mem_cke   <= 1'b0;
               {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} <= ENC_NOP;
               mem_ba    <= '0;
               mem_addr  <= '0;
               init_done <= 1'b0;
            end else begin
               mem_cke   <= e_cke;
               {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} <= e_ctl;
               mem_ba    <= e_ba;
               mem_addr  <= e_addr;
               init_done <= e_done;
            end
         end
      end else begin : g_out_comb
         assign mem_cke   = e_cke;
         assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = e_ctl;
         assign mem_ba    = e_ba;
         assign mem_addr  = e_addr;
         assign init_done = e_done;
      end
   endgenerate

   AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (rst)
      !mem_cke |-> ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == ENC_NOP)
                   && !init_done); // R1

   AST_CKE_HOLD: assert property (@(posedge clk) disable iff (rst)
      mem_cke |=> mem_cke); // R2

   AST_OCD_AFTER_DLL: assert property (@(posedge clk) disable iff (rst)
      (fire && (step == ST_OCD_DEF)) |-> dll_ok); // R6

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done); // R7

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
      init_done |-> mem_cke &&
                    ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == ENC_NOP)); // R7

endmodule

// File: tb/sim_ddr2_pwrup_seq.sv
module sim_ddr2_pwrup_seq;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        cke;
      logic        cs_n;
      logic        ras_n;
      logic        cas_n;
      logic        we_n;
      logic [2:0]  ba;
      logic [13:0] addr;
      logic        done;
   } bus_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   localparam logic [13:0] MR0 = 14'h0743, E10 = 14'h0385, E20 = 14'h0080, E30 = 14'h0000;
   localparam logic [13:0] MR1 = 14'h0652, E11 = 14'h0044, E21 = 14'h0000, E31 = 14'h0001;

   logic        c0_cke, c0_cs, c0_ras, c0_cas, c0_we, c0_done;
   logic [2:0]  c0_ba;
   logic [13:0] c0_addr;
   logic        c1_cke, c1_cs, c1_ras, c1_cas, c1_we, c1_done;
   logic [2:0]  c1_ba;
   logic [13:0] c1_addr;

   ddr2_pwrup_seq #(
      .ADDR_W(14), .BA_W(3), .PWRUP_CYC(20), .CKE_CYC(5), .TRP_CYC(3),
      .TMRD_CYC(2), .TRFC_CYC(6), .NUM_REF(3), .DLL_CYC(30), .REG_OUT(1'b0)
   ) u0 (
      .clk(clk), .rst(rst), .mr_cfg(MR0), .emr1_cfg(E10), .emr2_cfg(E20), .emr3_cfg(E30),
      .mem_cke(c0_cke), .mem_cs_n(c0_cs), .mem_ras_n(c0_ras), .mem_cas_n(c0_cas),
      .mem_we_n(c0_we), .mem_ba(c0_ba), .mem_addr(c0_addr), .init_done(c0_done)
   );

   ddr2_pwrup_seq #(
      .ADDR_W(14), .BA_W(3), .PWRUP_CYC(12), .CKE_CYC(3), .TRP_CYC(2),
      .TMRD_CYC(1), .TRFC_CYC(4), .NUM_REF(2), .DLL_CYC(4), .REG_OUT(1'b1)
   ) u1 (
      .clk(clk), .rst(rst), .mr_cfg(MR1), .emr1_cfg(E11), .emr2_cfg(E21), .emr3_cfg(E31),
      .mem_cke(c1_cke), .mem_cs_n(c1_cs), .mem_ras_n(c1_ras), .mem_cas_n(c1_cas),
      .mem_we_n(c1_we), .mem_ba(c1_ba), .mem_addr(c1_addr), .init_done(c1_done)
   );

   bus_t obs0, obs1;
   assign obs0 = {c0_cke, c0_cs, c0_ras, c0_cas, c0_we, c0_ba, c0_addr, c0_done};
   assign obs1 = {c1_cke, c1_cs, c1_ras, c1_cas, c1_we, c1_ba, c1_addr, c1_done};

   int   checks = 0;
   int   fails  = 0;
   bit   finished = 1'b0;
   bus_t q0[$], q1[$];
   string t0[$], t1[$];

   function automatic bus_t mk(logic cke, logic [3:0] ctl, logic [2:0] ba,
                               logic [13:0] addr, logic done);
      bus_t r;
      r.cke = cke; {r.cs_n, r.ras_n, r.cas_n, r.we_n} = ctl;
      r.ba = ba; r.addr = addr; r.done = done;
      return r;
   endfunction

   task automatic emit(ref bus_t q[$], ref string tq[$], input bus_t r,
                       input int gap, input string tag);
      q.push_back(r); tq.push_back(tag);
      for (int k = 1; k < gap; k++) begin
         q.push_back(mk(1'b1, 4'b0111, 3'd0, 14'd0, 1'b0));
         tq.push_back("R4");
      end
   endtask

   // behavioural expansion of the required sequence into a cycle trace
   task automatic build(ref bus_t q[$], ref string tq[$], input int pwr, input int ckc,
                        input int trp, input int tmrd, input int trfc, input int nref,
                        input int dll, input logic [13:0] mr, input logic [13:0] e1,
                        input logic [13:0] e2, input logic [13:0] e3);
      int td;
      logic [13:0] e1b;
      e1b = e1 & ~14'h0381;
      for (int k = 0; k < pwr; k++) begin
         q.push_back(mk(1'b0, 4'b0111, 3'd0, 14'd0, 1'b0)); tq.push_back("R1");
      end
      for (int k = 0; k < ckc; k++) begin
         q.push_back(mk(1'b1, 4'b0111, 3'd0, 14'd0, 1'b0)); tq.push_back("R2");
      end
      emit(q, tq, mk(1'b1, 4'b0010, 3'd0, 14'h0400, 1'b0), trp, "R2");
      emit(q, tq, mk(1'b1, 4'b0000, 3'd2, e2, 1'b0), tmrd, "R3");
      emit(q, tq, mk(1'b1, 4'b0000, 3'd3, e3, 1'b0), tmrd, "R3");
      emit(q, tq, mk(1'b1, 4'b0000, 3'd1, e1b, 1'b0), tmrd, "R3");
      td = q.size();
      emit(q, tq, mk(1'b1, 4'b0000, 3'd0, mr | 14'h0100, 1'b0), tmrd, "R3");
      emit(q, tq, mk(1'b1, 4'b0010, 3'd0, 14'h0400, 1'b0), trp, "R5");
      for (int k = 0; k < nref; k++)
         emit(q, tq, mk(1'b1, 4'b0001, 3'd0, 14'd0, 1'b0), trfc, "R5");
      emit(q, tq, mk(1'b1, 4'b0000, 3'd0, mr & ~14'h0100, 1'b0), tmrd, "R5");
      while (q.size() < td + dll) begin
         q.push_back(mk(1'b1, 4'b0111, 3'd0, 14'd0, 1'b0)); tq.push_back("R6");
      end
      emit(q, tq, mk(1'b1, 4'b0000, 3'd1, e1b | 14'h0380, 1'b0), tmrd, "R6");
      emit(q, tq, mk(1'b1, 4'b0000, 3'd1, e1b, 1'b0), tmrd, "R6");
   endtask

   task automatic cmp(input string who, input string tag, input int cyc,
                      input bus_t act, input bus_t exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, who, cyc, act, exp);
      end
   endtask

   function automatic bus_t exp_at(ref bus_t q[$], input int i);
      if (i < q.size()) return q[i];
      return mk(1'b1, 4'b0111, 3'd0, 14'd0, 1'b1);
   endfunction

   function automatic string tag_at(ref string tq[$], input int i);
      if (i < tq.size()) return tq[i];
      return "R7";
   endfunction

   initial begin
      int n;
      build(q0, t0, 20, 5, 3, 2, 6, 3, 30, MR0, E10, E20, E30);
      build(q1, t1, 12, 3, 2, 1, 4, 2, 4, MR1, E11, E21, E31);
      repeat (3) @(posedge clk);
      @(negedge clk);
      cmp("u0 in reset", "R1", -1, obs0, q0[0]);
      cmp("u1 in reset", "R1", -1, obs1, q1[0]);
      rst = 1'b0;
      n = ((q0.size() > q1.size()) ? q0.size() : q1.size()) + 10;
      for (int i = 0; i < n; i++) begin
         #1;
         cmp("u0", tag_at(t0, i), i, obs0, exp_at(q0, i));
         if (i == 0) cmp("u1 R8", tag_at(t1, 0), i, obs1, exp_at(q1, 0));
         else        cmp("u1 R8", tag_at(t1, i-1), i, obs1, exp_at(q1, i-1));
         @(negedge clk);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R7 watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule